// File: doc/BRIEF.md
# Optical Drive Nibble Command Link

This block sits on the drive side of a narrow link between an optical drive and its host controller. Once every sector period it sends the host a status frame and then takes in a command frame. Each frame is ten 4-bit nibbles. Nibble 0 is the identifier, nibbles 1 to 8 are parameters, and nibble 9 is a checksum. Each nibble is paced by a toggle handshake that uses two strobes. The host drives one strobe and the drive drives the other. Every change of a strobe level moves one nibble or acknowledges one.

The status payload (nibbles 0 to 8) is a plain parallel input. The block samples it at the start of each sector period and adds the checksum itself. A received command frame with a correct checksum appears on `cmd_frame` together with a one-cycle `cmd_valid` pulse. This output is valid-only and has no back-pressure: the consumer must take the frame in the cycle the pulse is high, and `cmd_frame` then holds it until the next good frame. A frame with a wrong checksum raises `csum_err` instead. When an exchange completes, the active-low interrupt goes low for a set number of cycles. A music/data flag follows the track type, which is sampled once per sector period.

Top module: `nibble_link_drive`

## Requirements
- R1: After reset, `drv_stb`=0, `drv_nib`=0, `irq_n`=1, `cmd_valid`=0, `csum_err`=0 and `md_flag`=0.
- R2: A sector tick occurs every SECTOR_CYC cycles. A status frame starts on a tick only while `link_en`=1. While `link_en`=0, `drv_stb` never changes.
- R3: Status nibble k (k=0..8) equals `stat_payload[4k+3:4k]`. Nibble 9 is the low 4 bits of the bitwise inverse of the sum of nibbles 0..8. Each nibble is on `drv_nib` at least one cycle before `drv_stb` toggles. The next nibble is sent only after the host toggles `hst_stb`.
- R4: After the tenth status acknowledge, each `hst_stb` toggle latches `host_nib` as the next command nibble (nibble k into `cmd_frame[4k+3:4k]`). The drive acknowledges each one by toggling `drv_stb` within 4 cycles.
- R5: If the command checksum nibble matches the rule of R3, `cmd_valid` is high for exactly one cycle, `cmd_frame` carries the ten nibbles and `csum_err`=0.
- R6: If the checksum does not match, `csum_err`=1, there is no `cmd_valid` pulse and `cmd_frame` is unchanged. `csum_err` stays high until the next complete frame with a good checksum.
- R7: After the tenth command nibble is latched, `irq_n` is low for exactly IRQ_CYC cycles and then returns high. It falls in the same cycle that `cmd_valid` or `csum_err` is set.
- R8: If no `hst_stb` toggle arrives within TIMEOUT_CYC cycles during a frame, the frame is abandoned with no interrupt and no `cmd_valid`. The next sector starts again at nibble 0.
- R9: `md_flag` takes the value of `trk_is_audio` (1 = audio) at every sector tick, whatever the state of `link_en`.
- R10: `hst_stb` toggles outside a frame are ignored and cause no `drv_stb` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_en | input | 1 | Host has enabled the link |
| trk_is_audio | input | 1 | Current disc data is audio (1) or data (0) |
| stat_payload | input | 36 | Status nibbles 0..8, nibble k at bits 4k+3:4k |
| hst_stb | input | 1 | Host strobe (toggle handshake) |
| host_nib | input | 4 | Command nibble from host |
| drv_stb | output | 1 | Drive strobe (toggle handshake) |
| drv_nib | output | 4 | Status nibble to host |
| irq_n | output | 1 | Active-low end-of-exchange interrupt |
| md_flag | output | 1 | Music/data flag |
| cmd_valid | output | 1 | One-cycle pulse: good command frame |
| cmd_frame | output | 40 | Last good command frame |
| csum_err | output | 1 | Last completed command frame had a bad checksum |

## Verification
A frame index that drifts out of step with the handshake shows at the ports at once. Status nibbles come out of order or with a wrong checksum, or the interrupt fires after fewer than ten command toggles, and the host model sees either within one nibble period. A timeout counter that is stuck or never clears shows up within TIMEOUT_CYC cycles. Either a stalled host still gets an interrupt, or a live exchange aborts, and the next frame then starts at nibble 0 in the following sector. Errors in the checksum path or the error flag show up within one cycle of the last nibble, as a `cmd_valid`, `csum_err` or `cmd_frame` value that disagrees with the bench's own sum.

// File: rtl/nlink_pkg.sv
package nlink_pkg;
  localparam int NIB_W      = 4;
  localparam int FRAME_NIBS = 10;
  localparam int PAY_NIBS   = FRAME_NIBS - 1;
  localparam int PAY_W      = PAY_NIBS * NIB_W;
  localparam int FRAME_W    = FRAME_NIBS * NIB_W;

  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TX_PUT, ST_TX_TGL, ST_TX_ACK, ST_RX, ST_FIN
  } link_st_t;

  // inverted 4-bit sum of the payload nibbles
  function automatic nib_t frame_csum(input logic [PAY_W-1:0] pay);
    nib_t s;
    s = '0;
    for (int k = 0; k < PAY_NIBS; k++) s = s + pay[k*NIB_W +: NIB_W];
    return ~s;
  endfunction
endpackage

// File: rtl/nlink_sector_timer.sv
module nlink_sector_timer #(
  parameter int SECTOR_CYC = 1666667
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (SECTOR_CYC > 1) ? $clog2(SECTOR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SECTOR_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/nlink_irq_stretch.sv
module nlink_irq_stretch #(
  parameter int IRQ_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic irq_n
);
  localparam int CW = $clog2(IRQ_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(IRQ_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      irq_n <= 1'b1;
    end else if (start) begin
      cnt   <= LOAD;
      irq_n <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      irq_n <= 1'b1;
    end
  end
endmodule

// File: rtl/nlink_frame_engine.sv
module nlink_frame_engine
  import nlink_pkg::*;
#(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sect_tick,
  input  logic               link_en,
  input  logic [PAY_W-1:0]   stat_payload,
  input  logic               hst_stb,
  input  nib_t               host_nib,
  output logic               drv_stb,
  output nib_t               drv_nib,
  output logic               cmd_valid,
  output logic [FRAME_W-1:0] cmd_frame,
  output logic               csum_err,
  output logic               xfer_done
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [3:0]    IDX_LAST = 4'(FRAME_NIBS - 1);

  link_st_t           st;
  logic [2:0]         hs_sync;
  logic               host_edge;
  logic [3:0]         idx;
  logic [TW-1:0]      tmo;
  logic [FRAME_W-1:0] tx_frame, rx_frame;
  logic               rx_good;

  // host strobe crosses in through two flops; third flop detects the toggle
  always_ff @(posedge clk) begin
    if (!rst_n) hs_sync <= '0;
    else        hs_sync <= {hs_sync[1:0], hst_stb};
  end
  assign host_edge = hs_sync[2] ^ hs_sync[1];

  assign rx_good   = (frame_csum(rx_frame[PAY_W-1:0]) == rx_frame[FRAME_W-1 -: NIB_W]);
  assign xfer_done = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      tmo       <= '0;
      tx_frame  <= '0;
      rx_frame  <= '0;
      drv_stb   <= 1'b0;
      drv_nib   <= '0;
      cmd_valid <= 1'b0;
      cmd_frame <= '0;
      csum_err  <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (sect_tick && link_en) begin
          tx_frame <= {frame_csum(stat_payload), stat_payload};
          idx      <= '0;
          st       <= ST_TX_PUT;
        end
        ST_TX_PUT: begin
          drv_nib <= tx_frame[idx*NIB_W +: NIB_W];
          st      <= ST_TX_TGL;
        end
        ST_TX_TGL: begin
          drv_stb <= ~drv_stb;
          tmo     <= '0;
          st      <= ST_TX_ACK;
        end
        ST_TX_ACK: begin
          if (host_edge) begin
            if (idx == IDX_LAST) begin
              idx <= '0;
              tmo <= '0;
              st  <= ST_RX;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_TX_PUT;
            end
          end else if (tmo == TMO_LAST) begin
            st <= ST_IDLE;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        ST_RX: begin
          if (host_edge) begin
            rx_frame[idx*NIB_W +: NIB_W] <= host_nib;
            drv_stb <= ~drv_stb;
            tmo     <= '0;
            if (idx == IDX_LAST) st <= ST_FIN;
            else                 idx <= idx + 1'b1;
          end else if (tmo == TMO_LAST) begin
            st <= ST_IDLE;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        ST_FIN: begin
          cmd_valid <= rx_good;
          csum_err  <= ~rx_good;
          if (rx_good) cmd_frame <= rx_frame;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nibble_link_drive.sv
module nibble_link_drive
  import nlink_pkg::*;
#(
  parameter int SECTOR_CYC  = 1666667,
  parameter int TIMEOUT_CYC = 100000,
  parameter int IRQ_CYC     = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_en,
  input  logic               trk_is_audio,
  input  logic [PAY_W-1:0]   stat_payload,
  input  logic               hst_stb,
  input  logic [NIB_W-1:0]   host_nib,
  output logic               drv_stb,
  output logic [NIB_W-1:0]   drv_nib,
  output logic               irq_n,
  output logic               md_flag,
  output logic               cmd_valid,
  output logic [FRAME_W-1:0] cmd_frame,
  output logic               csum_err
);
  logic sect_tick;
  logic xfer_done;

  nlink_sector_timer #(.SECTOR_CYC(SECTOR_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(sect_tick)
  );

  nlink_frame_engine #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .sect_tick(sect_tick), .link_en(link_en),
    .stat_payload(stat_payload), .hst_stb(hst_stb), .host_nib(host_nib),
    .drv_stb(drv_stb), .drv_nib(drv_nib), .cmd_valid(cmd_valid),
    .cmd_frame(cmd_frame), .csum_err(csum_err), .xfer_done(xfer_done)
  );

  nlink_irq_stretch #(.IRQ_CYC(IRQ_CYC)) u_irq (
    .clk(clk), .rst_n(rst_n), .start(xfer_done), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         md_flag <= 1'b0;
    else if (sect_tick) md_flag <= trk_is_audio;
  end
endmodule

// File: rtl/nlink_checker.sv
module nlink_checker
  import nlink_pkg::*;
#(
  parameter int IRQ_CYC = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               drv_stb,
  input logic [NIB_W-1:0]   drv_nib,
  input logic               irq_n,
  input logic               cmd_valid,
  input logic [FRAME_W-1:0] cmd_frame,
  input logic               csum_err
);
  int lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      lowcnt <= 0;
    else if (!irq_n) lowcnt <= lowcnt + 1;
    else             lowcnt <= 0;
  end

  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r5_valid_checksum: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (frame_csum(cmd_frame[PAY_W-1:0]) == cmd_frame[FRAME_W-1 -: NIB_W]) && !csum_err);

  a_r3_nib_before_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_stb) |-> $stable(drv_nib));

  a_r7_irq_width: assert property (@(posedge clk) disable iff (!rst_n)
    lowcnt <= IRQ_CYC);

  a_r7_irq_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> (cmd_valid || csum_err));
endmodule

bind nibble_link_drive nlink_checker #(.IRQ_CYC(IRQ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_stb(drv_stb), .drv_nib(drv_nib),
  .irq_n(irq_n), .cmd_valid(cmd_valid), .cmd_frame(cmd_frame), .csum_err(csum_err)
);

// File: tb/test_nibble_link_drive.sv
module test_nibble_link_drive;
  localparam int SECTOR  = 3000;
  localparam int TMO     = 200;
  localparam int IRQ     = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_en = 1'b0;
  logic        trk_is_audio = 1'b0;
  logic [35:0] stat_payload = '0;
  logic        hst_stb = 1'b0;
  logic [3:0]  host_nib = '0;
  logic        drv_stb;
  logic [3:0]  drv_nib;
  logic        irq_n, md_flag, cmd_valid, csum_err;
  logic [39:0] cmd_frame;

  int  nchecks = 0;
  int  nfail   = 0;
  logic last_ds = 1'b0;
  logic [39:0] last_good = '0;

  always #4 clk = ~clk;

  nibble_link_drive #(.SECTOR_CYC(SECTOR), .TIMEOUT_CYC(TMO), .IRQ_CYC(IRQ)) i_nibble_link_drive (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .trk_is_audio(trk_is_audio),
    .stat_payload(stat_payload), .hst_stb(hst_stb), .host_nib(host_nib),
    .drv_stb(drv_stb), .drv_nib(drv_nib), .irq_n(irq_n), .md_flag(md_flag),
    .cmd_valid(cmd_valid), .cmd_frame(cmd_frame), .csum_err(csum_err)
  );

  function automatic logic [3:0] sum_inv(input logic [35:0] p);
    logic [3:0] s = '0;
    for (int k = 0; k < 9; k++) s = s + p[k*4 +: 4];
    return ~s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_toggle(input int maxc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < maxc && !seen; i++) begin
      @(negedge clk);
      if (drv_stb !== last_ds) begin
        last_ds = drv_stb;
        seen = 1'b1;
      end
    end
  endtask

  task automatic host_toggle();
    @(negedge clk);
    hst_stb = ~hst_stb;
  endtask

  // full exchange: status frame check, then send cmdf
  task automatic exchange(input logic [35:0] pay, input logic [39:0] cmdf, input bit stall);
    bit seen;
    bit good;
    logic [3:0] exp;
    int lows;
    stat_payload = pay;
    good = (sum_inv(cmdf[35:0]) == cmdf[39:36]);
    for (int k = 0; k < 10; k++) begin
      wait_toggle(k == 0 ? SECTOR + 300 : 50, seen);
      chk(seen, "R3 status strobe toggle", 64'(seen), 64'd1);
      exp = (k < 9) ? pay[k*4 +: 4] : sum_inv(pay);
      chk(drv_nib === exp, "R3 status nibble", 64'(drv_nib), 64'(exp));
      if (stall && k == 2) begin
        repeat (40) @(negedge clk);
        chk(drv_stb === last_ds, "R3 waits for host ack", 64'(drv_stb), 64'(last_ds));
      end
      host_toggle();
    end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      host_nib = cmdf[k*4 +: 4];
      host_toggle();
      wait_toggle(6, seen);
      chk(seen, "R4 command nibble ack", 64'(seen), 64'd1);
    end
    @(negedge clk);
    if (good) begin
      chk(cmd_valid === 1'b1, "R5 cmd_valid pulse", 64'(cmd_valid), 64'd1);
      chk(cmd_frame === cmdf, "R5 cmd_frame", 64'(cmd_frame), 64'(cmdf));
      chk(csum_err === 1'b0, "R5 csum_err low", 64'(csum_err), 64'd0);
      last_good = cmdf;
    end else begin
      chk(cmd_valid === 1'b0, "R6 no cmd_valid", 64'(cmd_valid), 64'd0);
      chk(csum_err === 1'b1, "R6 csum_err high", 64'(csum_err), 64'd1);
      chk(cmd_frame === last_good, "R6 cmd_frame kept", 64'(cmd_frame), 64'(last_good));
    end
    chk(irq_n === 1'b0, "R7 irq falls with result", 64'(irq_n), 64'd0);
    lows = 1;
    @(negedge clk);
    chk(cmd_valid === 1'b0, "R5 single-cycle pulse", 64'(cmd_valid), 64'd0);
    while (irq_n === 1'b0 && lows < 200) begin
      lows++;
      @(negedge clk);
    end
    chk(lows == IRQ, "R7 irq low width", 64'(lows), 64'(IRQ));
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk(drv_stb === 1'b0 && drv_nib === 4'h0, "R1 strobe/nibble reset", {59'd0, drv_stb, drv_nib}, 64'd0);
    chk(irq_n === 1'b1, "R1 irq_n reset", 64'(irq_n), 64'd1);
    chk(cmd_valid === 1'b0 && csum_err === 1'b0 && md_flag === 1'b0, "R1 flags reset",
        {61'd0, cmd_valid, csum_err, md_flag}, 64'd0);
  endtask

  task automatic t_link_off();
    bit moved = 1'b0;
    link_en = 1'b0;
    trk_is_audio = 1'b1;
    host_toggle();
    repeat (10) @(negedge clk);
    host_toggle();
    for (int i = 0; i < SECTOR + 50; i++) begin
      @(negedge clk);
      if (drv_stb !== last_ds) moved = 1'b1;
    end
    chk(!moved, "R2 R10 no frame while link off, host toggles ignored", 64'(moved), 64'd0);
    chk(md_flag === 1'b1, "R9 md_flag audio", 64'(md_flag), 64'd1);
  endtask

  task automatic t_good();
    link_en = 1'b1;
    exchange(36'h0_0000_0003, {sum_inv(36'h1_2345_678A), 36'h1_2345_678A}, 1'b1);
    exchange(36'hF_EDCB_A987, {sum_inv(36'h0_0000_0000), 36'h0_0000_0000}, 1'b0);
  endtask

  task automatic t_bad();
    exchange(36'h5_5555_5555, {~sum_inv(36'h9_0000_0001), 36'h9_0000_0001}, 1'b0);
    exchange(36'h0_0000_0001, {sum_inv(36'hF_FFFF_FFFF), 36'hF_FFFF_FFFF}, 1'b0);
    chk(csum_err === 1'b0, "R6 csum_err cleared by good frame", 64'(csum_err), 64'd0);
  endtask

  task automatic t_timeout();
    bit seen;
    bit bad_evt = 1'b0;
    stat_payload = 36'h2_4682_4682;
    for (int k = 0; k < 3; k++) begin
      wait_toggle(k == 0 ? SECTOR + 300 : 50, seen);
      host_toggle();
    end
    wait_toggle(50, seen);
    for (int i = 0; i < TMO + 40; i++) begin
      @(negedge clk);
      if (irq_n !== 1'b1 || cmd_valid !== 1'b0 || drv_stb !== last_ds) bad_evt = 1'b1;
    end
    chk(!bad_evt, "R8 abort without irq or cmd_valid", 64'(bad_evt), 64'd0);
    exchange(36'h7_1111_2222, {sum_inv(36'hC_0000_0000), 36'hC_0000_0000}, 1'b0);
  endtask

  task automatic t_md_data();
    trk_is_audio = 1'b0;
    link_en = 1'b0;
    repeat (SECTOR + 20) @(negedge clk);
    chk(md_flag === 1'b0, "R9 md_flag data", 64'(md_flag), 64'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_link_off();
    t_good();
    t_bad();
    t_timeout();
    t_md_data();
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule